// File: doc/BRIEF.md
# Interrupt Pending and Enable Register Pair

This block collects interrupt requests from peripheral lines into a pending register and qualifies them with an enable register. Both registers are mapped into a small I/O window. The processor reaches them with 16-bit or 32-bit accesses. A processor write to the pending register acknowledges requests: each written 0 clears a pending bit, and each written 1 leaves that bit as it is. A single registered interrupt line goes high while any pending bit is also enabled.

Chosen request sources can be marked as always asserted through a parameter. Such a source comes back on each pending-register write whose data holds a 1 in its position. The block does no prioritisation and no vectoring. Software reads the pending register and decides what to service.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the pending register, the enable register and `irq_o` are all zero.
- R2: A high request line `req[i]` sets pending bit i at the next clock edge. The bit stays set until it is acknowledged.
- R3: A 32-bit write to the pending register (offset 0x070) sets it to the old value AND the written data.
- R4: If a request and an acknowledge write that clears the same bit arrive in the same cycle, the bit is set after the edge.
- R5: A 32-bit write to the enable register (offset 0x074) replaces all of its bits. The enable register changes on no other event.
- R6: A 16-bit write (`wide`=0) changes only bits 15:0 of the addressed register. Bits 31:16 keep their value.
- R7: Pending bits named in `STICKY` (bit 7 and bit 9 by default) are ORed into the old pending value before the AND of a pending-register write. Writing 1 to such a bit sets it, and writing 0 clears it.
- R8: `irq_o` equals the OR over all bits of (pending AND enable), delayed by exactly one clock edge.
- R9: `rdata` shows the addressed register at once, and reading has no side effect. Offsets other than 0x070 and 0x074 read as zero, and writes to them change nothing.
- R10: A 16-bit read (`wide`=0) returns bits 15:0 of the register, with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_SRC | Peripheral request lines, level sampled each cycle |
| wr_en | input | 1 | Register write strobe |
| wide | input | 1 | Access size: 1 = 32-bit, 0 = 16-bit |
| addr | input | ADDR_W | Byte offset within the I/O window |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data for `addr` and `wide` |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The request path is swept one line at a time. Each single-bit pulse shows whether that source lands in its own position and whether it stays latched. Acknowledge writes are tried with single-zero masks, all-ones and all-zeros data. These show a true AND apart from a plain load, and they show the always-asserted bits apart from ordinary ones. A request that collides with a clearing write shows whether the request takes priority. Enable patterns with alternating and half-word bits, written at both access sizes and read at both sizes, separate the lanes. Each enable change is followed by a check of the interrupt line, which confirms the one-edge delay.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_regdec.sv
module irq_regdec
  import irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h070,
  parameter logic [ADDR_W-1:0] MASK_OFF = 'h074
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wide,
  output reg_sel_e          sel,
  output logic              stat_wr_lo,
  output logic              stat_wr_hi,
  output logic              mask_wr_lo,
  output logic              mask_wr_hi
);
  always_comb begin
    if (addr == STAT_OFF)      sel = SEL_STAT;
    else if (addr == MASK_OFF) sel = SEL_MASK;
    else                       sel = SEL_NONE;
  end

  // low half is written by every access size, high half only by wide ones
  always_comb begin
    stat_wr_lo = wr_en && (sel == SEL_STAT);
    mask_wr_lo = wr_en && (sel == SEL_MASK);
    stat_wr_hi = stat_wr_lo && wide;
    mask_wr_hi = mask_wr_lo && wide;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int               REG_W   = 32,
  parameter int               NUM_SRC = 11,
  parameter logic [REG_W-1:0] STICKY  = 32'h0000_0280
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   stat_q
);
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] req_ext;
  logic [REG_W-1:0] kept;
  logic [REG_W-1:0] stat_d;
  logic             stat_en;
  logic [1:0]       lane_wr;

  assign req_ext = REG_W'(req);
  assign kept    = stat_q | STICKY;
  assign lane_wr = {wr_hi, wr_lo};

  // per-lane acknowledge, then new requests override any clear
  always_comb begin
    stat_d = stat_q;
    for (int l = 0; l < 2; l++) begin
      if (lane_wr[l]) stat_d[l*HALF +: HALF] = kept[l*HALF +: HALF] & wdata[l*HALF +: HALF];
    end
    stat_d  = stat_d | req_ext;
    stat_en = wr_lo | wr_hi | (|req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mask_q
);
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] mask_d;
  logic             mask_en;
  logic [1:0]       lane_wr;

  assign lane_wr = {wr_hi, wr_lo};

  always_comb begin
    mask_d = mask_q;
    for (int l = 0; l < 2; l++) begin
      if (lane_wr[l]) mask_d[l*HALF +: HALF] = wdata[l*HALF +: HALF];
    end
    mask_en = wr_lo | wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int               ADDR_W   = 12,
  parameter int               REG_W    = 32,
  parameter int               NUM_SRC  = 11,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h070,
  parameter logic [ADDR_W-1:0] MASK_OFF = 'h074,
  parameter logic [REG_W-1:0] STICKY   = 32'h0000_0280
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               wr_en,
  input  logic               wide,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic               irq_o
);
  localparam int HALF = REG_W / 2;

  reg_sel_e         sel;
  logic             stat_wr_lo, stat_wr_hi, mask_wr_lo, mask_wr_hi;
  logic [REG_W-1:0] stat_q, mask_q;
  logic [REG_W-1:0] rd_full;
  logic             irq_d;

  irq_regdec #(.ADDR_W(ADDR_W), .STAT_OFF(STAT_OFF), .MASK_OFF(MASK_OFF)) u_dec (
    .addr(addr), .wr_en(wr_en), .wide(wide), .sel(sel),
    .stat_wr_lo(stat_wr_lo), .stat_wr_hi(stat_wr_hi),
    .mask_wr_lo(mask_wr_lo), .mask_wr_hi(mask_wr_hi)
  );

  irq_status_reg #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .STICKY(STICKY)) u_stat (
    .clk(clk), .rst_n(rst_n), .req(req),
    .wr_lo(stat_wr_lo), .wr_hi(stat_wr_hi), .wdata(wdata), .stat_q(stat_q)
  );

  irq_mask_reg #(.REG_W(REG_W)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(mask_wr_lo), .wr_hi(mask_wr_hi), .wdata(wdata), .mask_q(mask_q)
  );

  always_comb begin
    case (sel)
      SEL_STAT: rd_full = stat_q;
      SEL_MASK: rd_full = mask_q;
      default:  rd_full = '0;
    endcase
    rdata = wide ? rd_full : {{(REG_W-HALF){1'b0}}, rd_full[HALF-1:0]};
  end

  assign irq_d = |(stat_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int               ADDR_W   = 12,
  parameter int               REG_W    = 32,
  parameter int               NUM_SRC  = 11,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h070,
  parameter logic [ADDR_W-1:0] MASK_OFF = 'h074
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req,
  input logic               wr_en,
  input logic               wide,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   wdata,
  input logic [REG_W-1:0]   rdata,
  input logic               irq_o,
  input logic [REG_W-1:0]   stat_q,
  input logic [REG_W-1:0]   mask_q
);
  localparam int HALF = REG_W / 2;
  logic [REG_W-1:0] req_ext;
  assign req_ext = REG_W'(req);

  p_req_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> ((stat_q & $past(req_ext)) == $past(req_ext)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide && addr == STAT_OFF) |=>
      ((stat_q & ~$past(req_ext) & ~$past(wdata)) == '0));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == MASK_OFF) |=> $stable(mask_q));

  p_half_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide) |=> $stable(mask_q[REG_W-1:HALF]));

  p_irq_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(stat_q & mask_q))));

  p_narrow_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && addr == MASK_OFF) |-> (rdata == {{(REG_W-HALF){1'b0}}, mask_q[HALF-1:0]}));
endmodule

bind irq_status_unit irq_status_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_SRC(NUM_SRC),
  .STAT_OFF(STAT_OFF), .MASK_OFF(MASK_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .wide(wide),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  localparam int          NSRC   = 11;
  localparam logic [11:0] A_ST   = 12'h070;
  localparam logic [11:0] A_MK   = 12'h074;
  localparam logic [31:0] STICKY = 32'h0000_0280;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] req;
  logic            wr_en, wide;
  logic [11:0]     addr;
  logic [31:0]     wdata, rdata;
  logic            irq_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_st, m_mk;

  always #2.5 clk = ~clk;

  irq_status_unit dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .wide(wide),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model update, check irq at next negedge
  task automatic step(input logic [NSRC-1:0] r, input bit we, input bit wd,
                      input logic [11:0] a, input logic [31:0] d, input string tag);
    logic e_irq;
    req = r; wr_en = we; wide = wd; addr = a; wdata = d;
    e_irq = |(m_st & m_mk);
    if (we && a == A_ST) begin
      m_st[15:0] = (m_st[15:0] | STICKY[15:0]) & d[15:0];
      if (wd) m_st[31:16] = (m_st[31:16] | STICKY[31:16]) & d[31:16];
    end
    if (we && a == A_MK) begin
      m_mk[15:0] = d[15:0];
      if (wd) m_mk[31:16] = d[31:16];
    end
    m_st = m_st | 32'(r);
    @(posedge clk);
    @(negedge clk);
    req = '0; wr_en = 1'b0;
    chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, e_irq});
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input bit wd, input logic [31:0] exp);
    addr = a; wide = wd;
    #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic rd_both(input string tag);
    rd({tag, " st"}, A_ST, 1'b1, m_st);
    rd({tag, " mk"}, A_MK, 1'b1, m_mk);
  endtask

  initial begin : watchdog
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; wr_en = 1'b0; wide = 1'b1; addr = '0; wdata = '0;
    m_st = '0; m_mk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd_both("R1");
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 single-source sweep, each bit latched and kept
    for (int i = 0; i < NSRC; i++) begin
      step(NSRC'(1) << i, 1'b0, 1'b1, A_ST, '0, "R2");
      rd("R2 st", A_ST, 1'b1, m_st);
    end
    chk("R2 all latched", m_st, 32'h0000_07FF);

    // R3 acknowledge single bits with single-zero data
    for (int i = 0; i < NSRC; i += 2) begin
      step('0, 1'b1, 1'b1, A_ST, ~(32'h1 << i), "R3");
      rd("R3 st", A_ST, 1'b1, m_st);
    end
    // R7 always-asserted bits
    step('0, 1'b1, 1'b1, A_ST, 32'h0, "R7");
    rd("R7 cleared", A_ST, 1'b1, 32'h0);
    step('0, 1'b1, 1'b1, A_ST, 32'hFFFF_FFFF, "R7");
    rd("R7 sticky set", A_ST, 1'b1, 32'h0000_0280);
    step('0, 1'b1, 1'b1, A_ST, 32'hFFFF_FD7F, "R7");
    rd("R7 zero clears", A_ST, 1'b1, 32'h0);

    // R4 request beats a clearing write
    step(NSRC'(11'h008), 1'b0, 1'b1, A_ST, '0, "R4");
    step(NSRC'(11'h008), 1'b1, 1'b1, A_ST, 32'h0, "R4");
    rd("R4 bit kept", A_ST, 1'b1, 32'h0000_0008);

    // R5 and R8 enable sweep with irq lag
    for (int v = 0; v < 6; v++) begin
      logic [31:0] pat;
      pat = (v == 0) ? 32'h0 : (v == 1) ? 32'h0000_0008 : (v == 2) ? 32'hFFFF_FFF7 :
            (v == 3) ? 32'hAAAA_5555 : (v == 4) ? 32'h5555_AAAA : 32'hFFFF_FFFF;
      step('0, 1'b1, 1'b1, A_MK, pat, "R5");
      rd("R5 mk", A_MK, 1'b1, pat);
      step('0, 1'b0, 1'b1, A_ST, '0, "R8");
    end

    // R6 narrow writes touch only the low half
    step('0, 1'b1, 1'b1, A_MK, 32'hAAAA_5555, "R6");
    step('0, 1'b1, 1'b0, A_MK, 32'hFFFF_1234, "R6");
    rd("R6 mk", A_MK, 1'b1, 32'hAAAA_1234);
    step(NSRC'(11'h401), 1'b0, 1'b1, A_ST, '0, "R6");
    step('0, 1'b1, 1'b0, A_ST, 32'h0000_0400, "R6");
    rd("R6 st", A_ST, 1'b1, m_st);
    // R10 narrow read
    rd("R10 mk low", A_MK, 1'b0, 32'h0000_1234);
    rd("R10 st low", A_ST, 1'b0, {16'h0, m_st[15:0]});

    // R9 unmapped offsets
    step('0, 1'b1, 1'b1, 12'h078, 32'hFFFF_FFFF, "R9");
    step('0, 1'b1, 1'b1, 12'h000, 32'h0, "R9");
    rd_both("R9 untouched");
    rd("R9 other reads 0", 12'h078, 1'b1, 32'h0);
    rd("R9 reread st", A_ST, 1'b1, m_st);

    // R8 irq falls after the enable is cleared
    step('0, 1'b1, 1'b1, A_MK, 32'h0, "R8");
    step('0, 1'b0, 1'b1, A_ST, '0, "R8");
    chk("R8 irq low", {31'b0, irq_o}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule